// File: doc/BRIEF.md
# On-Screen-Display Pixel Unpack and Alpha Stage

This block sits between the on-screen-display fetch logic and the video mixer. It takes one raw 32-bit buffer word per cycle, with a lane number. It cuts one pixel container out of the word, which may be 8, 16 or 32 bits wide. It decodes that container by colour format and produces 8-bit red, green and blue values plus one effective 8-bit alpha. Indexed pixels are looked up in an internal 256-entry palette of ARGB words. Software loads the palette in two steps: it writes an index, then it writes the colour.

The container width and the colour format are set independently. Bits that the format does not use are padding and are ignored. A pixel can be made transparent through a colour key. It can also carry its own alpha, and a global alpha applies to the whole overlay. The key, the per-pixel alpha and the global alpha each have their own enable and can be used together.

The pipeline has a fixed depth of three clocks, with a valid flag going in and a valid flag coming out. Palette writes go to the memory alongside the pixel stream and never hold it up.

Top module: `osd_pixel_blend`

## Requirements
- R1: The format codes are 1 = 5:6:5 (red 15:11, green 10:5, blue 4:0), 2 = 5:5:5 (red 14:10, green 9:5, blue 4:0), 3 = 4:4:4 (red 11:8, green 7:4, blue 3:0) and 4 = ARGB 8:8:8:8 (alpha 31:24, red 23:16, green 15:8, blue 7:0). Any other code is handled as code 4. Channels narrower than 8 bits are widened by copying their top bits into the vacated low bits.
- R2: The container codes are 1 = 8 bits, taken from byte lane `pixLane` at bits 8*lane+7:8*lane, and 2 = 16 bits, taken from the half selected by `pixLane[0]` (0 = bits 15:0). Codes 3 and 0 use the whole word.
- R3: With an 8-bit container, the pixel is always decoded as 8-bit indexed, whatever the format code says.
- R4: Format code 5 is 8-bit indexed. The index is container bits 7:0, and the output is the ARGB palette entry, with its alpha in bits 31:24. A pulse on `palIdxWr` stores `palWrData[7:0]` as the pending index. A following pulse on `palDataWr` writes `palWrData` into that palette entry.
- R5: Container bits above the format's width are padding and do not affect the colour, the alpha or the key comparison.
- R6: With the key enabled, a matching pixel gets alpha 0, and its colour is still passed through. The 16-bit formats compare container bits 15:0 against `cfgKey[15:0]`. Indexed mode compares the index against `cfgKey[7:0]`. Code 4 compares all 32 bits.
- R7: The per-pixel alpha is used only when `cfgLocalEn` is set and the format is code 4 or indexed. In every other case it counts as 255. When the global alpha is disabled, it also counts as 255. With neither alpha in use, the output alpha is 255.
- R8: The effective alpha is floor((local × global + 127) / 255).
- R9: A pixel accepted with `pixValid` at a clock edge appears with `outValid` high after exactly three edges. Gaps in the input show up as gaps in the output.
- R10: Palette writes may happen in any cycle while pixels stream. Output timing does not change, and the written entry is used by later indexed pixels.
- R11: While reset is asserted, `outValid` and all colour and alpha outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 3 | Colour format code |
| cfgContainer | input | 2 | Bits-per-pixel container code |
| cfgGlobalEn | input | 1 | Global alpha enable |
| cfgLocalEn | input | 1 | Per-pixel alpha enable |
| cfgKeyEn | input | 1 | Colour key enable |
| cfgKey | input | 32 | Key colour |
| cfgGlobalAlpha | input | 8 | Global alpha value |
| palIdxWr | input | 1 | Load palette index strobe |
| palDataWr | input | 1 | Write palette colour strobe |
| palWrData | input | 32 | Palette index or colour |
| pixValid | input | 1 | Input word valid |
| pixWord | input | 32 | Raw buffer word |
| pixLane | input | 2 | Container position within the word |
| outValid | output | 1 | Output pixel valid |
| outR | output | 8 | Red |
| outG | output | 8 | Green |
| outB | output | 8 | Blue |
| outA | output | 8 | Effective alpha |

## Verification
The hardest case to produce from the ports is a palette write that lands while pixels are streaming back to back. Timing or data could be disturbed there without any visible stall. The bench forks a two-step palette load alongside an unbroken run of direct-colour pixels. It checks that every result arrives on its three-cycle stamp. It then reads the new entry through an indexed pixel. Key matches are aimed with garbage in the padding bits. Near-miss keys differ only in a bit that one format compares and another does not.

// File: rtl/osd_blend_pkg.sv
package osd_blend_pkg;
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned CH_W      = 8;
  parameter int unsigned PAL_IDX_W = 8;
  parameter int unsigned LANE_W    = 2;

  typedef enum logic [2:0] {
    MD_RGB565 = 3'd1,
    MD_RGB555 = 3'd2,
    MD_RGB444 = 3'd3,
    MD_ARGB32 = 3'd4,
    MD_INDEX8 = 3'd5
  } pixMode_e;

  localparam logic [1:0] CT_8  = 2'b01;
  localparam logic [1:0] CT_16 = 2'b10;
  localparam logic [1:0] CT_32 = 2'b11;

  typedef struct packed {
    logic                 palWe;
    logic [PAL_IDX_W-1:0] palAddr;
    logic [WORD_W-1:0]    palData;
    pixMode_e             mode;
    logic [1:0]           container;
    logic                 localUse;
    logic                 globalUse;
    logic                 keyUse;
  } osdCtl_t;

  // Widen a w-bit channel (right aligned in v) to 8 bits by bit replication.
  function automatic logic [7:0] widen(input logic [7:0] v, input int unsigned w);
    logic [7:0] hi;
    logic [7:0] lo;
    hi = v << (8 - w);
    lo = v >> (2 * w - 8);
    return hi | lo;
  endfunction
endpackage

// File: rtl/osd_ctrl.sv
module osd_ctrl
  import osd_blend_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgMode,
  input  logic [1:0]        cfgContainer,
  input  logic              cfgGlobalEn,
  input  logic              cfgLocalEn,
  input  logic              cfgKeyEn,
  input  logic              palIdxWr,
  input  logic              palDataWr,
  input  logic [WORD_W-1:0] palWrData,
  output osdCtl_t           ctl
);
  logic [PAL_IDX_W-1:0] palIdx;
  pixMode_e             effMode;
  logic [1:0]           effCont;

  // pending palette index, loaded by the first step of a palette update
  always_ff @(posedge clk) begin
    if (!rstN)         palIdx <= '0;
    else if (palIdxWr) palIdx <= palWrData[PAL_IDX_W-1:0];
  end

  // format decode: a byte container forces indexed decoding
  always_comb begin
    effCont = (cfgContainer == 2'b00) ? CT_32 : cfgContainer;
    if (effCont == CT_8) begin
      effMode = MD_INDEX8;
    end else begin
      case (cfgMode)
        3'd1:    effMode = MD_RGB565;
        3'd2:    effMode = MD_RGB555;
        3'd3:    effMode = MD_RGB444;
        3'd5:    effMode = MD_INDEX8;
        default: effMode = MD_ARGB32;
      endcase
    end
  end

  always_comb begin
    ctl.palWe     = palDataWr;
    ctl.palAddr   = palIdx;
    ctl.palData   = palWrData;
    ctl.mode      = effMode;
    ctl.container = effCont;
    ctl.localUse  = cfgLocalEn && (effMode == MD_ARGB32 || effMode == MD_INDEX8);
    ctl.globalUse = cfgGlobalEn;
    ctl.keyUse    = cfgKeyEn;
  end

  // R4: the pending index only moves on an index write
  a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !palIdxWr |=> $stable(palIdx));
endmodule

// File: rtl/osd_datapath.sv
module osd_datapath
  import osd_blend_pkg::*;
#(
  parameter int unsigned PAL_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  osdCtl_t           ctl,
  input  logic [WORD_W-1:0] cfgKey,
  input  logic [CH_W-1:0]   cfgGlobalAlpha,
  input  logic              pixValid,
  input  logic [WORD_W-1:0] pixWord,
  input  logic [LANE_W-1:0] pixLane,
  output logic              outValid,
  output logic [CH_W-1:0]   outR,
  output logic [CH_W-1:0]   outG,
  output logic [CH_W-1:0]   outB,
  output logic [CH_W-1:0]   outA
);
  localparam int unsigned NUM_BYTES = WORD_W / CH_W;
  localparam int unsigned HALF_W    = WORD_W / 2;
  localparam int unsigned PROD_W    = 2 * CH_W + 1;

  // ---------------- stage 0: container extraction and key compare
  logic [CH_W-1:0]   byteLane [NUM_BYTES];
  logic [HALF_W-1:0] halfLane [2];
  logic [WORD_W-1:0] cont;
  logic              keyHit;

  for (genvar gb = 0; gb < NUM_BYTES; gb++) begin : g_bytes
    assign byteLane[gb] = pixWord[gb*CH_W +: CH_W];
  end
  for (genvar gh = 0; gh < 2; gh++) begin : g_halves
    assign halfLane[gh] = pixWord[gh*HALF_W +: HALF_W];
  end

  always_comb begin
    case (ctl.container)
      CT_8:    cont = WORD_W'(byteLane[pixLane]);
      CT_16:   cont = WORD_W'(halfLane[pixLane[0]]);
      default: cont = pixWord;
    endcase
    case (ctl.mode)
      MD_RGB565, MD_RGB555, MD_RGB444: keyHit = (cont[15:0] == cfgKey[15:0]);
      MD_INDEX8: keyHit = (cont[PAL_IDX_W-1:0] == cfgKey[PAL_IDX_W-1:0]);
      default:   keyHit = (cont == cfgKey);
    endcase
    keyHit = keyHit && ctl.keyUse;
  end

  // palette: synchronous read, old data on a same-address write
  logic [WORD_W-1:0] palMem [PAL_DEPTH];
  logic [WORD_W-1:0] palQ;
  always_ff @(posedge clk) begin
    if (ctl.palWe) palMem[ctl.palAddr] <= ctl.palData;
    palQ <= palMem[cont[PAL_IDX_W-1:0]];
  end

  // ---------------- stage 1 registers
  logic              s1Valid, s1KeyHit, s1LocalUse, s1GlobalUse;
  pixMode_e          s1Mode;
  logic [WORD_W-1:0] s1Cont;
  logic [CH_W-1:0]   s1Ga;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0; s1KeyHit <= 1'b0; s1LocalUse <= 1'b0; s1GlobalUse <= 1'b0;
      s1Mode <= MD_ARGB32; s1Cont <= '0; s1Ga <= '0;
    end else begin
      s1Valid     <= pixValid;
      s1KeyHit    <= keyHit;
      s1LocalUse  <= ctl.localUse;
      s1GlobalUse <= ctl.globalUse;
      s1Mode      <= ctl.mode;
      s1Cont      <= cont;
      s1Ga        <= cfgGlobalAlpha;
    end
  end

  // ---------------- stage 1 combinational: channel expansion, alpha product
  logic [CH_W-1:0]   r1, g1, b1, srcA, la, ga;
  logic [PROD_W-1:0] prod;

  always_comb begin
    srcA = '1;
    case (s1Mode)
      MD_RGB565: begin
        r1 = widen({3'b0, s1Cont[15:11]}, 5);
        g1 = widen({2'b0, s1Cont[10:5]}, 6);
        b1 = widen({3'b0, s1Cont[4:0]}, 5);
      end
      MD_RGB555: begin
        r1 = widen({3'b0, s1Cont[14:10]}, 5);
        g1 = widen({3'b0, s1Cont[9:5]}, 5);
        b1 = widen({3'b0, s1Cont[4:0]}, 5);
      end
      MD_RGB444: begin
        r1 = widen({4'b0, s1Cont[11:8]}, 4);
        g1 = widen({4'b0, s1Cont[7:4]}, 4);
        b1 = widen({4'b0, s1Cont[3:0]}, 4);
      end
      MD_INDEX8: {srcA, r1, g1, b1} = palQ;
      default:   {srcA, r1, g1, b1} = s1Cont;
    endcase
    la   = s1LocalUse  ? srcA : '1;
    ga   = s1GlobalUse ? s1Ga : '1;
    prod = PROD_W'(la) * PROD_W'(ga) + PROD_W'(127);
  end

  // ---------------- stage 2 registers
  logic              s2Valid, s2KeyHit, s2LocalUse, s2GlobalUse;
  logic [CH_W-1:0]   s2R, s2G, s2B;
  logic [PROD_W-1:0] s2Prod;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Valid <= 1'b0; s2KeyHit <= 1'b0; s2LocalUse <= 1'b0; s2GlobalUse <= 1'b0;
      s2R <= '0; s2G <= '0; s2B <= '0; s2Prod <= '0;
    end else begin
      s2Valid     <= s1Valid;
      s2KeyHit    <= s1KeyHit;
      s2LocalUse  <= s1LocalUse;
      s2GlobalUse <= s1GlobalUse;
      s2R <= r1; s2G <= g1; s2B <= b1;
      s2Prod <= prod;
    end
  end

  // ---------------- stage 2 combinational: exact floor(p/255) for p < 65536
  logic [PROD_W:0]  divSum;
  logic [CH_W-1:0]  alphaQ;
  always_comb begin
    divSum = (PROD_W+1)'(s2Prod) + (PROD_W+1)'(1) + (PROD_W+1)'(s2Prod >> CH_W);
    alphaQ = divSum[CH_W +: CH_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0; outR <= '0; outG <= '0; outB <= '0; outA <= '0;
    end else begin
      outValid <= s2Valid;
      outR <= s2R; outG <= s2G; outB <= s2B;
      outA <= s2KeyHit ? '0 : alphaQ;
    end
  end

  // ---------------- assertions
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R9: fixed three-edge latency of the valid flag
  a_r9_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(pixValid, 3)));

  // R6: a keyed pixel leaves with zero alpha
  a_r6_key_clear: assert property (@(posedge clk) disable iff (!rstN)
    (s2Valid && s2KeyHit) |=> (outValid && outA == '0));

  // R7: no alpha source in use gives an opaque result
  a_r7_opaque: assert property (@(posedge clk) disable iff (!rstN)
    (s2Valid && !s2KeyHit && !s2LocalUse && !s2GlobalUse) |=> (outA == '1));
endmodule

// File: rtl/osd_pixel_blend.sv
module osd_pixel_blend
  import osd_blend_pkg::*;
#(
  parameter int unsigned PAL_DEPTH = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  cfgMode,
  input  logic [1:0]  cfgContainer,
  input  logic        cfgGlobalEn,
  input  logic        cfgLocalEn,
  input  logic        cfgKeyEn,
  input  logic [31:0] cfgKey,
  input  logic [7:0]  cfgGlobalAlpha,
  input  logic        palIdxWr,
  input  logic        palDataWr,
  input  logic [31:0] palWrData,
  input  logic        pixValid,
  input  logic [31:0] pixWord,
  input  logic [1:0]  pixLane,
  output logic        outValid,
  output logic [7:0]  outR,
  output logic [7:0]  outG,
  output logic [7:0]  outB,
  output logic [7:0]  outA
);
  osdCtl_t ctl;

  osd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgContainer(cfgContainer),
    .cfgGlobalEn(cfgGlobalEn), .cfgLocalEn(cfgLocalEn), .cfgKeyEn(cfgKeyEn),
    .palIdxWr(palIdxWr), .palDataWr(palDataWr), .palWrData(palWrData), .ctl(ctl)
  );

  osd_datapath #(.PAL_DEPTH(PAL_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgKey(cfgKey), .cfgGlobalAlpha(cfgGlobalAlpha),
    .pixValid(pixValid), .pixWord(pixWord), .pixLane(pixLane),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB), .outA(outA)
  );
endmodule

// File: tb/tb_osd_pixel_blend.sv
`timescale 1ns/1ps
module tb_osd_pixel_blend;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgMode = 3'd1;
  logic [1:0]  cfgContainer = 2'b10;
  logic        cfgGlobalEn = 1'b0, cfgLocalEn = 1'b0, cfgKeyEn = 1'b0;
  logic [31:0] cfgKey = '0;
  logic [7:0]  cfgGlobalAlpha = '0;
  logic        palIdxWr = 1'b0, palDataWr = 1'b0;
  logic [31:0] palWrData = '0;
  logic        pixValid = 1'b0;
  logic [31:0] pixWord = '0;
  logic [1:0]  pixLane = '0;
  logic        outValid;
  logic [7:0]  outR, outG, outB, outA;

  osd_pixel_blend dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] palShadow [256];
  logic [31:0] expQ [$];
  int          stampQ [$];
  string       tagQ [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] rep(input logic [7:0] v, input int w);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) r[7-i] = v[w-1-(i % w)];
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] w, input logic [1:0] lane);
    logic [31:0] c, argb;
    int m, la, gav, a;
    bit hit;
    if (cfgContainer == 2'b01)      c = (w >> (8*lane)) & 32'hFF;
    else if (cfgContainer == 2'b10) c = lane[0] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    else                            c = w;
    m = (cfgContainer == 2'b01) ? 5 : int'(cfgMode);
    case (m)
      1: begin argb = {8'hFF, rep({3'b0,c[15:11]},5), rep({2'b0,c[10:5]},6), rep({3'b0,c[4:0]},5)}; hit = c[15:0] == cfgKey[15:0]; end
      2: begin argb = {8'hFF, rep({3'b0,c[14:10]},5), rep({3'b0,c[9:5]},5), rep({3'b0,c[4:0]},5)}; hit = c[15:0] == cfgKey[15:0]; end
      3: begin argb = {8'hFF, rep({4'b0,c[11:8]},4), rep({4'b0,c[7:4]},4), rep({4'b0,c[3:0]},4)}; hit = c[15:0] == cfgKey[15:0]; end
      5: begin argb = palShadow[c[7:0]]; hit = c[7:0] == cfgKey[7:0]; end
      default: begin argb = c; hit = c == cfgKey; end
    endcase
    la  = (cfgLocalEn && (m == 4 || m == 5)) ? int'(argb[31:24]) : 255;
    gav = cfgGlobalEn ? int'(cfgGlobalAlpha) : 255;
    a   = (cfgKeyEn && hit) ? 0 : (la * gav + 127) / 255;
    return {8'(a), argb[23:0]};
  endfunction

  task automatic sendPix(input logic [31:0] w, input logic [1:0] lane, input string tag);
    expQ.push_back(model(w, lane));
    stampQ.push_back(cyc + 3);
    tagQ.push_back(tag);
    pixWord = w; pixLane = lane; pixValid = 1'b1;
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic palWr(input logic [7:0] idx, input logic [31:0] data);
    palIdxWr = 1'b1; palWrData = {24'h0, idx};
    @(negedge clk);
    palIdxWr = 1'b0; palDataWr = 1'b1; palWrData = data;
    @(negedge clk);
    palDataWr = 1'b0;
    palShadow[idx] = data;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected output", {outA, outR, outG, outB}, 32'h0);
      end else begin
        logic [31:0] e;
        int st;
        string tg;
        e = expQ.pop_front(); st = stampQ.pop_front(); tg = tagQ.pop_front();
        check({outA, outR, outG, outB} == e, tg, {outA, outR, outG, outB}, e);
        check(cyc == st, {tg, " R9 latency"}, 32'(cyc), 32'(st));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) palShadow[i] = 'x;
    idle(3);
    // R11: outputs quiet in reset
    check(outValid == 1'b0 && {outA, outR, outG, outB} == 32'h0, "R11 reset",
          {7'h0, outValid, outA, outR, outG, outB}, 32'h0);
    rstN = 1'b1;
    idle(2);

    // R4: palette loads
    palWr(8'd5,   32'h80112233);
    palWr(8'd200, 32'hFF445566);
    palWr(8'd0,   32'h10ABCDEF);
    palWr(8'd255, 32'h7F0000FF);
    idle(2);

    // R1/R2: 5:6:5 in a 16-bit container, both halves
    cfgMode = 3'd1; cfgContainer = 2'b10;
    sendPix(32'h0000F81F, 2'd0, "R1 565 magenta");
    sendPix(32'h07E00000, 2'd1, "R2 565 upper half");
    sendPix(32'h00008410, 2'd0, "R1 565 replicate");
    cfgMode = 3'd2;
    sendPix(32'h7C1F0000, 2'd1, "R1 555");
    cfgMode = 3'd3;
    sendPix(32'h00000A5F, 2'd0, "R1 444");
    // R1: ARGB with local alpha
    cfgMode = 3'd4; cfgContainer = 2'b11; cfgLocalEn = 1'b1;
    sendPix(32'h40C08020, 2'd0, "R1 argb local");
    // R7: local ignored for 5:6:5
    cfgMode = 3'd1;
    sendPix(32'h1234ABCD, 2'd0, "R7 local ignored");
    // R5: padding above 5:6:5 in a 32-bit container
    sendPix(32'hFFFF8410, 2'd0, "R5 565 padding");
    // R3: byte container forces indexed despite code 1
    cfgContainer = 2'b01; cfgMode = 3'd1;
    sendPix(32'h00050000, 2'd2, "R3 forced index lane2");
    sendPix(32'hFF000000, 2'd3, "R2 byte lane3");
    // R4/R5: indexed in a 32-bit container with padding
    cfgContainer = 2'b11; cfgMode = 3'd5;
    sendPix(32'hDEADBEC8, 2'd0, "R5 index padding");
    sendPix(32'h00000000, 2'd0, "R4 index 0");
    idle(4);

    // R8: combined alpha
    cfgMode = 3'd4; cfgLocalEn = 1'b1; cfgGlobalEn = 1'b1; cfgGlobalAlpha = 8'h80;
    sendPix(32'h80102030, 2'd0, "R8 half by half");
    cfgGlobalAlpha = 8'h01;
    sendPix(32'hFF102030, 2'd0, "R8 full by one");
    cfgGlobalAlpha = 8'hFF;
    sendPix(32'h00102030, 2'd0, "R8 local zero");
    cfgLocalEn = 1'b0; cfgGlobalAlpha = 8'h40;
    sendPix(32'h00102030, 2'd0, "R7 global only");
    cfgGlobalEn = 1'b0;
    sendPix(32'h00102030, 2'd0, "R7 none enabled");
    idle(1);
    sendPix(32'h11223344, 2'd0, "R9 after gap");
    idle(4);

    // R6: colour key
    cfgKeyEn = 1'b1; cfgKey = 32'hABCD1234; cfgMode = 3'd1; cfgContainer = 2'b11;
    sendPix(32'h55551234, 2'd0, "R6 565 key 16b padding");
    sendPix(32'h55551235, 2'd0, "R6 565 near miss");
    cfgMode = 3'd4; cfgKey = 32'h92345678; cfgLocalEn = 1'b1;
    sendPix(32'h92345678, 2'd0, "R6 argb match");
    sendPix(32'h12345678, 2'd0, "R6 argb bit31 differs");
    cfgMode = 3'd5; cfgKey = 32'hFFFFFFC8;
    sendPix(32'h000000C8, 2'd0, "R6 index key");
    cfgKeyEn = 1'b0; cfgLocalEn = 1'b0;
    idle(4);

    // R10: palette load concurrent with a back-to-back stream
    cfgMode = 3'd1; cfgContainer = 2'b10;
    fork
      palWr(8'd77, 32'hC0FFEE01);
      for (int i = 0; i < 6; i++) sendPix(32'h1000 * i + 32'h21, 2'd0, "R10 stream during write");
    join
    cfgMode = 3'd5; cfgContainer = 2'b11; cfgLocalEn = 1'b1;
    sendPix(32'h0000004D, 2'd0, "R10 new entry used");
    cfgLocalEn = 1'b0;
    idle(8);

    check(expQ.size() == 0, "R9 all outputs seen", 32'(expQ.size()), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule